// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits on the path from the synchronized transmit-data line to the enable of the bus low-side driver. A transmit line that is held low asks for a dominant bus, and a high line means recessive. The guard keeps a stuck-low line from holding the bus dominant forever. It counts microsecond ticks while the line stays low. When the count reaches a limit, it forces the driver recessive and latches a timeout state.

The latched state does not clear on a rising edge alone. The transmit line must stay high for a qualified number of consecutive ticks. Any low level seen before that point restarts the qualification. Dropping the communication-enable input, which means the transceiver has left its normal operating mode, holds the driver recessive and returns the guard to its armed state with both counters cleared.

Both time limits are counted in ticks of the `usTick` strobe, which is high for one clock cycle per microsecond. By default the low limit is 10000 ticks (10 ms) and the release qualification is 10 ticks (10 µs).

Top module: `txd_dom_guard`

## Requirements
- R1: While `rstN` is high, `commEn` is high and no timeout is latched, `drvDominant` equals the inverse of `txdSync` in the same cycle (`txdSync` = 0 requests dominant, 1 means recessive).
- R2: When `txdSync` is low for `LOW_LIMIT_US` consecutive `usTick` pulses with `commEn` high, the timeout latches on the edge that samples the last of those ticks. From the next cycle `timeoutFlag` is 1 and `drvDominant` is 0.
- R3: While the timeout is latched, `drvDominant` is 0 for any value of `txdSync`, and `timeoutFlag` stays 1.
- R4: The latch clears on the edge that samples the `HIGH_QUAL_US`-th consecutive `usTick` seen with `txdSync` high. After that edge `timeoutFlag` is 0, and a later low on `txdSync` drives dominant again.
- R5: A cycle with `txdSync` low while latched restarts the high-time qualification, so a high period shorter than `HIGH_QUAL_US` ticks leaves the latch set.
- R6: While armed, any cycle with `txdSync` high restarts the low-time count.
- R7: A cycle with `commEn` low clears the latch (so `timeoutFlag` is 0 from the next cycle) and clears both counters.
- R8: While `commEn` is low, `drvDominant` is 0, and ticks seen with `txdSync` low do not count toward the timeout.
- R9: While `rstN` is low, `drvDominant` and `timeoutFlag` are both 0, and the guard leaves reset armed with empty counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txdSync | input | 1 | Synchronized transmit data, 0 = dominant request |
| commEn | input | 1 | High when the transceiver is in normal communication mode |
| usTick | input | 1 | One-cycle strobe per microsecond |
| drvDominant | output | 1 | Enables the bus driver to pull the bus dominant |
| timeoutFlag | output | 1 | High while the dominant timeout is latched |

## Verification
The assertions check four things on every cycle. The driver is recessive whenever the line is high, whenever communication is disabled, and whenever the latch is set. A set or clear of the latch is always preceded by a tick at the right `txdSync` level. The counter bounds and the clear strobes are checked inside the datapath. The exact tick on which the latch sets or clears can only be shown by the bench's scenarios, which count the ticks they issue. The same holds for the restart of either count by a short opposite-level pulse, and for the fresh count after `commEn` is dropped.

// File: rtl/txd_dom_guard_pkg.sv
package txd_dom_guard_pkg;

  typedef struct packed {
    logic lowInc;
    logic lowClr;
    logic hiInc;
    logic hiClr;
  } guardStrb_t;

  typedef enum logic {
    ST_ARMED   = 1'b0,
    ST_TIMEOUT = 1'b1
  } guardState_t;

endpackage

// File: rtl/txd_dom_guard_dp.sv
module txd_dom_guard_dp
  import txd_dom_guard_pkg::*;
#(
  parameter int LOW_LIMIT_US = 10000,
  parameter int HIGH_QUAL_US = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  guardStrb_t strb,
  output logic       lowAtLimit,
  output logic       hiAtLimit
);

  localparam int LOW_W = $clog2(LOW_LIMIT_US + 1);
  localparam int HI_W  = $clog2(HIGH_QUAL_US + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(LOW_LIMIT_US - 1);
  localparam logic [HI_W-1:0]  HI_LAST  = HI_W'(HIGH_QUAL_US - 1);

  logic [LOW_W-1:0] lowCnt;
  logic [HI_W-1:0]  hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (strb.lowClr) begin
      lowCnt <= '0;
    end else if (strb.lowInc) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= '0;
    end else if (strb.hiClr) begin
      hiCnt <= '0;
    end else if (strb.hiInc) begin
      hiCnt <= hiCnt + 1'b1;
    end
  end

  assign lowAtLimit = (lowCnt == LOW_LAST);
  assign hiAtLimit  = (hiCnt == HI_LAST);

  AST_LOW_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LOW_LAST); // R2
  AST_HI_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    hiCnt <= HI_LAST); // R4
  AST_HI_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.hiClr |=> hiCnt == '0); // R5
  AST_LOW_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.lowClr |=> lowCnt == '0); // R6

endmodule

// File: rtl/txd_dom_guard_ctrl.sv
module txd_dom_guard_ctrl
  import txd_dom_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txdSync,
  input  logic       commEn,
  input  logic       usTick,
  input  logic       lowAtLimit,
  input  logic       hiAtLimit,
  output guardStrb_t strb,
  output logic       drvDominant,
  output logic       timeoutFlag
);

  guardState_t state, stateNxt;

  always_comb begin
    stateNxt   = state;
    strb       = '0;
    if (!commEn) begin
      strb.lowClr = 1'b1;
      strb.hiClr  = 1'b1;
      stateNxt    = ST_ARMED;
    end else begin
      case (state)
        ST_ARMED: begin
          strb.hiClr = 1'b1;
          if (txdSync) begin
            strb.lowClr = 1'b1;
          end else if (usTick) begin
            if (lowAtLimit) begin
              strb.lowClr = 1'b1;
              stateNxt    = ST_TIMEOUT;
            end else begin
              strb.lowInc = 1'b1;
            end
          end
        end
        ST_TIMEOUT: begin
          strb.lowClr = 1'b1;
          if (!txdSync) begin
            strb.hiClr = 1'b1;
          end else if (usTick) begin
            if (hiAtLimit) begin
              strb.hiClr = 1'b1;
              stateNxt   = ST_ARMED;
            end else begin
              strb.hiInc = 1'b1;
            end
          end
        end
        default: stateNxt = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_ARMED;
    end else begin
      state <= stateNxt;
    end
  end

  assign drvDominant = rstN & commEn & ~txdSync & (state == ST_ARMED);
  assign timeoutFlag = (state == ST_TIMEOUT);

  AST_HIGH_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    txdSync |-> !drvDominant); // R1
  AST_LATCH_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> !drvDominant); // R3
  AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(!txdSync && usTick && commEn)); // R2
  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(timeoutFlag) && $past(commEn)) |-> $past(txdSync && usTick)); // R4
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !commEn |=> !timeoutFlag); // R7
  AST_EN_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !commEn |-> !drvDominant); // R8

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
  import txd_dom_guard_pkg::*;
#(
  parameter int LOW_LIMIT_US = 10000,
  parameter int HIGH_QUAL_US = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic txdSync,
  input  logic commEn,
  input  logic usTick,
  output logic drvDominant,
  output logic timeoutFlag
);

  guardStrb_t strb;
  logic       lowAtLimit;
  logic       hiAtLimit;

  txd_dom_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txdSync    (txdSync),
    .commEn     (commEn),
    .usTick     (usTick),
    .lowAtLimit (lowAtLimit),
    .hiAtLimit  (hiAtLimit),
    .strb       (strb),
    .drvDominant(drvDominant),
    .timeoutFlag(timeoutFlag)
  );

  txd_dom_guard_dp #(
    .LOW_LIMIT_US(LOW_LIMIT_US),
    .HIGH_QUAL_US(HIGH_QUAL_US)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lowAtLimit(lowAtLimit),
    .hiAtLimit (hiAtLimit)
  );

endmodule

// File: tb/txd_dom_guard_bench.sv
module txd_dom_guard_bench;

  localparam int LOW_L  = 5;
  localparam int HIGH_Q = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txdSync = 1'b1;
  logic commEn = 1'b0;
  logic usTick = 1'b0;
  logic drvDominant;
  logic timeoutFlag;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 1'b0;

  logic [1:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  txd_dom_guard #(
    .LOW_LIMIT_US(LOW_L),
    .HIGH_QUAL_US(HIGH_Q)
  ) u_txd_dom_guard (
    .clk        (clk),
    .rstN       (rstN),
    .txdSync    (txdSync),
    .commEn     (commEn),
    .usTick     (usTick),
    .drvDominant(drvDominant),
    .timeoutFlag(timeoutFlag)
  );

  // Driver: apply inputs for one cycle and queue the outputs expected after the edge.
  task automatic step(input logic txd, input logic en, input logic tick,
                      input logic expDrv, input logic expTo, input string tag);
    @(negedge clk);
    txdSync = txd;
    commEn  = en;
    usTick  = tick;
    expQ.push_back({expDrv, expTo});
    tagQ.push_back(tag);
  endtask

  // Monitor: compare 3 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (expQ.size() > 0) begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        testsRun++;
        if ({drvDominant, timeoutFlag} !== e) begin
          testsFail++;
          $display("FAIL %s: drv/timeout actual %b%b expected %b%b",
                   t, drvDominant, timeoutFlag, e[1], e[0]);
        end
      end
    end
  end

  initial begin
    // R9: reset holds the driver recessive even with a dominant request
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    @(negedge clk);
    rstN = 1'b1;
    // R1: follow txdSync while armed
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
    // R2: LOW_L-1 ticks still dominant, the LOW_L-th latches
    for (int i = 0; i < LOW_L - 1; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R2");
    // R3: held recessive while latched
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    // R5: short high period followed by a low restarts qualification
    for (int i = 0; i < HIGH_Q - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    for (int i = 0; i < HIGH_Q - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
    // R4: the HIGH_Q-th consecutive high tick releases
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
    // R6: a high cycle restarts the low count
    for (int i = 0; i < LOW_L - 2; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < LOW_L - 1; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R2");
    // R7: dropping commEn clears the latch and the count
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    for (int i = 0; i < LOW_L - 1; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    // R8: commEn low forces recessive and ticks do not count
    for (int i = 0; i < LOW_L + 1; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    for (int i = 0; i < LOW_L - 1; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule